// File: doc/BRIEF.md
# Dual-Lane Two-Stage Multiply-Accumulate Unit

This block is a signed two's complement multiply-accumulate engine with operands `OP_W` bits wide (32 by default). One datapath serves three widths of work. It can run one full-width operation, one operation on the low half of each operand, or two independent half-width operations side by side. Each of these can accumulate or just multiply. Stage one masks, inverts and offsets the partial-product rows to suit the chosen width, then reduces them to a carry-save pair. Stage two resolves that pair per lane, adds it to the accumulator register and saturates the accumulated value at the output.

The accumulator is laid out as two lanes. Each lane has `OP_W` data bits and `GUARD` guard bits (8 by default). In full mode, the low lane's guard field is skipped: the data carry jumps straight into the upper lane, which then acts as the high data word plus the guard bits of the wide sum. A three-bit mode code enters with every operation and is registered along with its data, so every operation is computed in its own mode. One new operation can be accepted on every clock cycle.

Top module: `dtm_mac`

## Requirements
- R1: Mode code decoding works as follows. Bit 0 = 1 selects half width. Bits 1 and 0 both set select dual half width. Bit 2 = 1 selects multiply-only. The defined codes are 000 full MAC, 001 single half MAC, 011 dual half MAC, 100 full multiply, 101 single half multiply and 111 dual half multiply. Codes 010 and 110 behave as 000 and 100.
- R2: Operands, mode and clear sampled at clock edge k produce `result` right after edge k+1. A new operation can be issued on every edge.
- R3: In full mode the accumulator adds the signed 64-bit product `op_a*op_b`. `result[63:0]` shows the saturated 64-bit accumulated value.
- R4: In single half mode the unit uses only `op_a[15:0]*op_b[15:0]` (signed). `result[31:0]` is the saturated 32-bit accumulated value and `result[63:32]` is zero. Operand bits [31:16] have no effect.
- R5: In dual mode the low lane accumulates `op_a[15:0]*op_b[15:0]` into `result[31:0]`. The high lane accumulates `op_a[31:16]*op_b[31:16]` into `result[63:32]`. Neither lane carries into or borrows from the other.
- R6: When mode bit 2 is set, the result is the saturated product of that operation alone. The earlier accumulator contents are ignored.
- R7: An operation issued with `acc_clr` = 1 starts a fresh accumulation from its own product.
- R8: Each lane keeps `GUARD` guard bits above its data width: 64+8 bits in full mode and 32+8 bits per lane in half modes. An intermediate sum that leaves the output range returns exactly once it comes back in range.
- R9: When the accumulated value is above the output maximum, the output is 0111..1. When it is below the minimum, the output is 1000..0. In dual mode each lane is judged and clamped on its own.
- R10: Back-to-back operations in different modes, each issued with a clear, each produce the result of their own mode.
- R11: While `rst_n` is low at a clock edge, the pipeline and accumulator are cleared, and `result` is zero after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_a | input | 32 | Multiplicand; in half modes lanes are [15:0] and [31:16] |
| op_b | input | 32 | Multiplier; same lane split as `op_a` |
| mode | input | 3 | Operation mode code (see R1) |
| acc_clr | input | 1 | Start a new accumulation with this operation |
| result | output | 64 | Saturated full result, or lane results in [31:0] and [63:32] |

## Verification
Because the mode is carried down the pipeline, stage one can hold one mode's carry-save pair while stage two completes an operation in a different mode. The bench provokes this collision by issuing operations in different modes on consecutive cycles, covering every code including the two aliases. Each result is judged against a signed reference computed for that operation's own mode, two cycles after issue. A second collision is dual mode with both lanes saturating at once in opposite directions. This is judged by requiring both clamp values in the same output word.

// File: rtl/dtm_pkg.sv
// Shared types for the dual-lane MAC. Assumes mode codes as defined in R1.
package dtm_pkg;

    // Decoded operation mode carried down the pipeline
    typedef struct packed {
        logic mul_only;
        logic narrow;
        logic dual;
    } mode_t;

    // Turns the three-bit mode code into its control flags
    function automatic mode_t decode_mode(input logic [2:0] code);
        mode_t m;
        m.mul_only = code[2];
        m.narrow   = code[0];
        m.dual     = code[0] & code[1];
        return m;
    endfunction

endpackage

// File: rtl/dtm_ppgen.sv
// Stage-one logic: builds the partial-product rows for the chosen width and
// reduces them to a carry-save pair. Assumes OP_W is even. In half modes the
// rows are confined to their lane and the carry into bit OP_W is cut.
module dtm_ppgen
    import dtm_pkg::*;
#(
    parameter int OP_W = 32
) (
    input  logic [OP_W-1:0]   a_i,
    input  logic [OP_W-1:0]   b_i,
    input  mode_t             md_i,
    output logic [2*OP_W-1:0] sum_o,
    output logic [2*OP_W-1:0] carry_o
);
    localparam int HALF = OP_W / 2;
    localparam int PW   = 2 * OP_W;
    localparam int NROW = OP_W + 1;

    logic [NROW-1:0][PW-1:0] rows;
    logic [PW-1:0]   a_full;
    logic [OP_W-1:0] a_lo_x;
    logic [OP_W-1:0] a_hi_x;

    assign a_full = {{OP_W{a_i[OP_W-1]}}, a_i};
    assign a_lo_x = {{HALF{a_i[HALF-1]}}, a_i[HALF-1:0]};
    assign a_hi_x = {{HALF{a_i[OP_W-1]}}, a_i[OP_W-1:HALF]};

    genvar gi;
    for (gi = 0; gi < OP_W; gi++) begin : g_row
        logic [PW-1:0]   full_pos;
        logic [PW-1:0]   full_r;
        logic [OP_W-1:0] lane_pos;
        logic [OP_W-1:0] lane_r;
        logic [PW-1:0]   half_r;
        // Full-width row; the sign row is inverted (its +1 sits in the constant row)
        assign full_pos = b_i[gi] ? (a_full << gi) : '0;
        assign full_r   = (gi == OP_W - 1) ? ~full_pos : full_pos;
        if (gi < HALF) begin : g_lo
            // Low-lane row, masked to the low OP_W bits
            assign lane_pos = b_i[gi] ? (a_lo_x << gi) : '0;
            assign lane_r   = (gi == HALF - 1) ? ~lane_pos : lane_pos;
            assign half_r   = {{OP_W{1'b0}}, lane_r};
        end else begin : g_hi
            // High-lane row, present only in dual mode
            assign lane_pos = b_i[gi] ? (a_hi_x << (gi - HALF)) : '0;
            assign lane_r   = (gi == OP_W - 1) ? ~lane_pos : lane_pos;
            assign half_r   = md_i.dual ? {lane_r, {OP_W{1'b0}}} : '0;
        end
        assign rows[gi] = md_i.narrow ? half_r : full_r;
    end

    // Constant row: +1 per inverted sign row, placed at each active lane's LSB
    assign rows[OP_W] = {{(OP_W-1){1'b0}}, md_i.narrow & md_i.dual,
                         {(OP_W-1){1'b0}}, 1'b1};

    logic [PW-1:0] s_acc, c_acc, s_new, c_maj;

    // Linear 3:2 reduction of all rows, cutting the lane-crossing carry in half modes
    always_comb begin
        s_acc = rows[0];
        c_acc = rows[1];
        s_new = '0;
        c_maj = '0;
        for (int k = 2; k < NROW; k++) begin
            s_new = s_acc ^ c_acc ^ rows[k];
            c_maj = (s_acc & c_acc) | (s_acc & rows[k]) | (c_acc & rows[k]);
            c_acc = c_maj << 1;
            if (md_i.narrow) c_acc[OP_W] = 1'b0;
            s_acc = s_new;
        end
    end

    assign sum_o   = s_acc;
    assign carry_o = c_acc;

endmodule

// File: rtl/dtm_accum.sv
// Stage-two adder: resolves the carry-save pair per lane, extends its sign
// into the guard bits and adds it to the accumulator feedback. In full mode
// the low lane's guard field is skipped and the data carry goes to the high lane.
module dtm_accum
    import dtm_pkg::*;
#(
    parameter int OP_W  = 32,
    parameter int GUARD = 8
) (
    input  logic [2*OP_W-1:0]         sum_i,
    input  logic [2*OP_W-1:0]         carry_i,
    input  logic [2*(OP_W+GUARD)-1:0] acc_i,
    input  mode_t                     md_i,
    input  logic                      clr_i,
    output logic [2*(OP_W+GUARD)-1:0] acc_o
);
    localparam int LW    = OP_W + GUARD;
    localparam int ACC_W = 2 * LW;

    logic [OP_W:0]   p_lo;
    logic [OP_W-1:0] p_hi;
    logic [LW-1:0]   fb_lo, fb_hi;
    logic [OP_W:0]   f_lo;
    logic [LW-1:0]   f_hi, n_lo, n_hi;
    logic            drop;

    // Per-lane product resolution and lane-split accumulate
    always_comb begin
        drop  = md_i.mul_only | clr_i;
        p_lo  = {1'b0, sum_i[OP_W-1:0]} + {1'b0, carry_i[OP_W-1:0]};
        p_hi  = sum_i[2*OP_W-1:OP_W] + carry_i[2*OP_W-1:OP_W]
              + OP_W'(p_lo[OP_W] & ~md_i.narrow);
        fb_lo = drop ? '0 : acc_i[LW-1:0];
        fb_hi = (drop || (md_i.narrow && !md_i.dual)) ? '0 : acc_i[ACC_W-1:LW];
        f_lo  = {1'b0, fb_lo[OP_W-1:0]} + {1'b0, p_lo[OP_W-1:0]};
        f_hi  = fb_hi + {{GUARD{p_hi[OP_W-1]}}, p_hi} + LW'(f_lo[OP_W]);
        n_lo  = fb_lo + {{GUARD{p_lo[OP_W-1]}}, p_lo[OP_W-1:0]};
        n_hi  = fb_hi + (md_i.dual ? {{GUARD{p_hi[OP_W-1]}}, p_hi} : '0);
        if (md_i.narrow) acc_o = {n_hi, n_lo};
        else             acc_o = {f_hi, {GUARD{1'b0}}, f_lo[OP_W-1:0]};
    end

endmodule

// File: rtl/dtm_clamp.sv
// Symmetric saturation: passes the low OUT_W bits when all bits from OUT_W-1
// upward agree, otherwise returns the signed maximum or minimum of OUT_W bits.
module dtm_clamp #(
    parameter int IN_W  = 40,
    parameter int OUT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IN_W-1:0]  val_i,
    output logic [OUT_W-1:0] sat_o
);
    localparam logic [OUT_W-1:0] OMAX = {1'b0, {(OUT_W-1){1'b1}}};
    localparam logic [OUT_W-1:0] OMIN = {1'b1, {(OUT_W-1){1'b0}}};
    localparam logic signed [IN_W-1:0] VMAX = IN_W'(OMAX);
    localparam logic signed [IN_W-1:0] VMIN = -VMAX - 1;

    logic in_range;

    // Guard-bit agreement test and clamp selection
    always_comb begin
        in_range = (&val_i[IN_W-1:OUT_W-1]) | ~(|val_i[IN_W-1:OUT_W-1]);
        if (in_range)          sat_o = val_i[OUT_W-1:0];
        else if (val_i[IN_W-1]) sat_o = OMIN;
        else                   sat_o = OMAX;
    end

    // R9
    sat_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($signed(val_i) > VMAX) |-> (sat_o == OMAX));
    // R9
    sat_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($signed(val_i) < VMIN) |-> (sat_o == OMIN));
    // R8
    pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (($signed(val_i) <= VMAX) && ($signed(val_i) >= VMIN))
        |-> ($signed(sat_o) == $signed(val_i)));

endmodule

// File: rtl/dtm_mac.sv
// Two-stage signed MAC with full, single-half and dual-half modes. Stage one
// registers a carry-save pair and the decoded mode; stage two accumulates into
// a two-lane register with guard bits; saturation follows the register.
// Assumes a clear is issued whenever the accumulating mode changes.
module dtm_mac
    import dtm_pkg::*;
#(
    parameter int OP_W  = 32,
    parameter int GUARD = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [OP_W-1:0]   op_a,
    input  logic [OP_W-1:0]   op_b,
    input  logic [2:0]        mode,
    input  logic              acc_clr,
    output logic [2*OP_W-1:0] result
);
    localparam int PW    = 2 * OP_W;
    localparam int LW    = OP_W + GUARD;
    localparam int ACC_W = 2 * LW;

    mode_t            md_in, md1, md2;
    logic [PW-1:0]    pp_sum, pp_carry, s1_sum, s1_carry;
    logic             clr1;
    logic [ACC_W-1:0] acc_nxt, acc_q;
    logic [PW-1:0]    full_sat;
    logic [OP_W-1:0]  lo_sat, hi_sat;

    assign md_in = decode_mode(mode);

    dtm_ppgen #(.OP_W(OP_W)) u_pp (
        .a_i(op_a), .b_i(op_b), .md_i(md_in),
        .sum_o(pp_sum), .carry_o(pp_carry)
    );

    // Stage-one register: carry-save pair, mode and clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_sum   <= '0;
            s1_carry <= '0;
            md1      <= '0;
            clr1     <= 1'b0;
        end else begin
            s1_sum   <= pp_sum;
            s1_carry <= pp_carry;
            md1      <= md_in;
            clr1     <= acc_clr;
        end
    end

    dtm_accum #(.OP_W(OP_W), .GUARD(GUARD)) u_acc (
        .sum_i(s1_sum), .carry_i(s1_carry), .acc_i(acc_q),
        .md_i(md1), .clr_i(clr1), .acc_o(acc_nxt)
    );

    // Stage-two register: accumulator and the mode used for saturation
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
            md2   <= '0;
        end else begin
            acc_q <= acc_nxt;
            md2   <= md1;
        end
    end

    dtm_clamp #(.IN_W(LW + OP_W), .OUT_W(PW)) u_sat_full (
        .clk(clk), .rst_n(rst_n),
        .val_i({acc_q[ACC_W-1:LW], acc_q[OP_W-1:0]}), .sat_o(full_sat)
    );
    dtm_clamp #(.IN_W(LW), .OUT_W(OP_W)) u_sat_lo (
        .clk(clk), .rst_n(rst_n), .val_i(acc_q[LW-1:0]), .sat_o(lo_sat)
    );
    dtm_clamp #(.IN_W(LW), .OUT_W(OP_W)) u_sat_hi (
        .clk(clk), .rst_n(rst_n), .val_i(acc_q[ACC_W-1:LW]), .sat_o(hi_sat)
    );

    // Output lane selection by the stage-two mode
    always_comb begin
        if (!md2.narrow) result = full_sat;
        else             result = {md2.dual ? hi_sat : {OP_W{1'b0}}, lo_sat};
    end

    // R8
    full_guard_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !md2.narrow |-> (acc_q[LW-1:OP_W] == '0));
    // R4
    single_upper_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (md1.narrow && !md1.dual) |-> (s1_sum[PW-1:OP_W] == '0 && s1_carry[PW-1:OP_W] == '0));
    // R11
    reset_zero_chk: assert property (@(posedge clk)
        !rst_n |=> (result == '0));

endmodule

// File: tb/dtm_mac_bench.sv
// Directed bench for dtm_mac: every op is checked two cycles after issue
// against signed reference arithmetic.
module dtm_mac_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] op_a = '0, op_b = '0;
    logic [2:0]  mode = 3'b100;
    logic        acc_clr = 1'b1;
    logic [63:0] result;

    int total = 0;
    int bad   = 0;

    logic signed [71:0] facc = '0;
    logic signed [39:0] lacc = '0, hacc = '0;
    logic [63:0] pexp [2];
    bit          pv   [2];
    string       ptag [2];

    dtm_mac u_dtm_mac (
        .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b),
        .mode(mode), .acc_clr(acc_clr), .result(result)
    );

    always #2 clk = ~clk;

    function automatic logic [31:0] sat32(input logic signed [39:0] v);
        if (v > 40'sh007fffffff) return 32'h7fffffff;
        if (v < -40'sh0080000000) return 32'h80000000;
        return v[31:0];
    endfunction

    function automatic logic [63:0] sat64(input logic signed [71:0] v);
        if (v > 72'sh007fffffffffffffff) return 64'h7fffffffffffffff;
        if (v < -72'sh008000000000000000) return 64'h8000000000000000;
        return v[63:0];
    endfunction

    task automatic check(input logic [63:0] got, input logic [63:0] exp, input string tag);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // Drives one op at a falling edge after checking the op issued two cycles earlier
    task automatic issue(input logic [31:0] a, input logic [31:0] b, input logic [2:0] m,
                         input logic clr, input bit chk, input string tag);
        logic signed [63:0] pf;
        logic signed [31:0] pl, ph;
        logic [63:0] e;
        @(negedge clk);
        if (pv[1]) check(result, pexp[1], ptag[1]);
        pv[1] = pv[0]; pexp[1] = pexp[0]; ptag[1] = ptag[0];
        pf = $signed(a) * $signed(b);
        pl = $signed(a[15:0]) * $signed(b[15:0]);
        ph = $signed(a[31:16]) * $signed(b[31:16]);
        if (m[0]) begin
            lacc = ((m[2] || clr) ? 40'sd0 : lacc) + pl;
            hacc = (m[1] ? (((m[2] || clr) ? 40'sd0 : hacc) + ph) : 40'sd0);
            e = {m[1] ? sat32(hacc) : 32'h0, sat32(lacc)};
        end else begin
            facc = ((m[2] || clr) ? 72'sd0 : facc) + pf;
            e = sat64(facc);
        end
        pv[0] = chk; pexp[0] = e; ptag[0] = tag;
        op_a = a; op_b = b; mode = m; acc_clr = clr;
    endtask

    task automatic flush();
        issue(32'h0, 32'h0, 3'b100, 1'b1, 1'b0, "idle");
        issue(32'h0, 32'h0, 3'b100, 1'b1, 1'b0, "idle");
        issue(32'h0, 32'h0, 3'b100, 1'b1, 1'b0, "idle");
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; op_a = '0; op_b = '0; mode = 3'b100; acc_clr = 1'b1;
        pv[0] = 1'b0; pv[1] = 1'b0;
        facc = '0; lacc = '0; hacc = '0;
        @(negedge clk);
        @(negedge clk);
        check(result, 64'h0, "R11 reset");
        rst_n = 1'b1;
    endtask

    task automatic t_full_mac();
        issue(32'd3, 32'd5, 3'b000, 1'b1, 1'b1, "R3 R7 first");
        issue(-32'sd7, 32'd100, 3'b000, 1'b0, 1'b1, "R3 acc neg");
        issue(32'h7fffffff, 32'h7fffffff, 3'b000, 1'b0, 1'b1, "R3 big");
        issue(32'h80000000, 32'h00000003, 3'b000, 1'b0, 1'b1, "R2 R3 stream");
        issue(32'h12345678, 32'h9abcdef0, 3'b000, 1'b1, 1'b1, "R7 restart");
        flush();
    endtask

    task automatic t_half_mac();
        issue(32'hdead0005, 32'hbeef0007, 3'b001, 1'b1, 1'b1, "R4 upper ignored");
        issue(32'h1234fff9, 32'h56780064, 3'b001, 1'b0, 1'b1, "R4 acc neg");
        issue(32'hffff8000, 32'h00007fff, 3'b001, 1'b0, 1'b1, "R4 min x max");
        flush();
    endtask

    task automatic t_dual_mac();
        issue(32'h0003ffff, 32'h00050001, 3'b011, 1'b1, 1'b1, "R5 low borrow");
        issue(32'hfff90002, 32'h00640003, 3'b011, 1'b0, 1'b1, "R5 lanes");
        issue(32'h7fff8000, 32'h7fff8000, 3'b011, 1'b0, 1'b1, "R5 extremes");
        flush();
    endtask

    task automatic t_mult_only();
        issue(32'd1000, 32'd1000, 3'b000, 1'b1, 1'b1, "R6 seed");
        issue(32'd6, 32'd7, 3'b100, 1'b0, 1'b1, "R6 full mult");
        issue(-32'sd6, 32'd7, 3'b100, 1'b0, 1'b1, "R6 full mult2");
        issue(32'hffff0009, 32'h0000fffd, 3'b101, 1'b0, 1'b1, "R6 half mult");
        issue(32'h00020009, 32'hfffd0004, 3'b111, 1'b0, 1'b1, "R6 dual mult");
        issue(32'h00020009, 32'hfffd0004, 3'b111, 1'b0, 1'b1, "R6 dual mult again");
        flush();
    endtask

    task automatic t_guard();
        for (int i = 0; i < 3; i++)
            issue(32'h80000000, 32'h80000000, 3'b000, (i == 0), 1'b1, "R8 full up");
        for (int i = 0; i < 2; i++)
            issue(32'h80000000, 32'h40000000, 3'b000, 1'b0, 1'b1, "R8 full back");
        for (int i = 0; i < 3; i++)
            issue(32'h00008000, 32'h00008000, 3'b001, (i == 0), 1'b1, "R8 half up");
        for (int i = 0; i < 2; i++)
            issue(32'h00008000, 32'h00007fff, 3'b001, 1'b0, 1'b1, "R8 half back");
        flush();
    endtask

    task automatic t_sat();
        for (int i = 0; i < 3; i++)
            issue(32'h80000000, 32'h7fffffff, 3'b000, (i == 0), 1'b1, "R9 full min");
        for (int i = 0; i < 3; i++)
            issue(32'h80008000, 32'h7fff8000, 3'b011, (i == 0), 1'b1, "R9 dual both");
        flush();
    endtask

    task automatic t_switch();
        issue(32'h00050007, 32'h0003fffe, 3'b000, 1'b1, 1'b1, "R10 full");
        issue(32'h00050007, 32'h0003fffe, 3'b001, 1'b1, 1'b1, "R10 single");
        issue(32'h00050007, 32'h0003fffe, 3'b011, 1'b1, 1'b1, "R10 dual");
        issue(32'h00050007, 32'h0003fffe, 3'b010, 1'b1, 1'b1, "R1 alias 010");
        issue(32'h00050007, 32'h0003fffe, 3'b101, 1'b1, 1'b1, "R10 half mult");
        issue(32'hfffb0007, 32'h0003fffe, 3'b110, 1'b1, 1'b1, "R1 alias 110");
        issue(32'h00050007, 32'h0003fffe, 3'b111, 1'b1, 1'b1, "R1 dual mult");
        issue(32'h00050007, 32'h0003fffe, 3'b100, 1'b1, 1'b1, "R1 full mult");
        flush();
    endtask

    task automatic t_mid_reset();
        issue(32'd9, 32'd9, 3'b000, 1'b1, 1'b0, "pre");
        issue(32'd9, 32'd9, 3'b000, 1'b0, 1'b0, "pre");
        do_reset();
        issue(32'h0000fffe, 32'h00000011, 3'b001, 1'b0, 1'b1, "R11 fresh acc");
        flush();
    endtask

    initial begin
        #400000;
        bad++;
        total++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        pv[0] = 1'b0; pv[1] = 1'b0;
        do_reset();
        t_full_mac();
        t_half_mac();
        t_dual_mac();
        t_mult_only();
        t_guard();
        t_sat();
        t_switch();
        t_mid_reset();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule